// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank synchronous DRAM interface. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines together with the bank and address inputs. It turns them into one of eight operations, and it keeps, for each bank, whether a row is open and which row that is. A command that would break the bank rules is refused and reported on an error pulse. A legal command is reported on an issue pulse with its operation code and bank.

Reads and writes can ask for an automatic close of their bank once the burst is over. The block counts the burst out per bank and closes the row by itself. A deselected cycle stops new commands but lets these countdowns run on. A low clock enable freezes the whole block, which covers suspend and power-down. The memory array, analog timing and self-refresh exit are outside this block.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted and at its release, every bank is closed, no auto-close is pending, and `issued_vld` and `err_vld` are low.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as follows: 011 activate (code 1), 101 read (code 2), 100 write (code 3), 010 precharge (code 4, or code 5 when `addr[10]` is high), 001 refresh (code 6) and 000 mode set (code 7). 111 and 110 are no-operations that report nothing. A legal command pulses `issued_vld` with `issued_op` and `issued_bank` for the cycle after its sampling edge.
- R3: An activate to a closed bank opens it and stores `addr` as its row. The row appears in `row_flat[b*13 +: 13]`. An activate to an open bank pulses `err_vld` and changes nothing.
- R4: A read or write to a bank that is closed, or whose auto-close is pending, pulses `err_vld` and is not issued. `issued_vld` and `err_vld` are never high together.
- R5: A read or write issued with `addr[10]` high sets `ap_pending` for its bank. The bank then closes at the BURST_LEN-th enabled edge after the command's edge. With `addr[10]` low the row stays open.
- R6: A precharge with `addr[10]` low closes only bank `ba`, even one with an auto-close pending. With `addr[10]` high it closes all four banks, whatever `ba` holds. A precharge to a bank that is already closed is legal.
- R7: Refresh and mode set are issued only when all banks are closed. Otherwise `err_vld` pulses. A bank whose auto-close finishes on the same edge still counts as open.
- R8: With `cs_n` high, no command is decoded and neither pulse fires, but pending auto-close countdowns keep running.
- R9: With `cke` sampled low, bank state, rows and countdowns hold, and neither pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable, low freezes the block |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address; bit 10 is the auto-close or all-bank flag |
| issued_vld | output | 1 | Pulse: a legal command was accepted |
| issued_op | output | 3 | Code of the accepted command |
| issued_bank | output | 2 | Bank of the accepted command |
| err_vld | output | 1 | Pulse: an illegal command was refused |
| bank_open | output | 4 | Per-bank open flag |
| ap_pending | output | 4 | Per-bank auto-close pending flag |
| row_flat | output | 52 | Open row of each bank, 13 bits per bank |

## Verification
An auto-close countdown can run out on the same edge at which a new command for the banks arrives. The bench provokes this in two ways. In the first, it issues a read with auto-close, waits three no-operations, and then sends a refresh on the fourth edge. The refresh must be refused, because the bank still counted as open when the refresh was sampled, and the bank must read closed right after that edge. A refresh on the next edge must then be issued. In the second, it sends a precharge-all on that same expiring edge. The precharge-all must be issued and must leave every bank closed, with no error.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_MRS  = 3'd7
  } trk_op_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    all_flag,
  output trk_op_e op
);
  always_comb begin
    op = OP_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_RD;
        3'b100:  op = OP_WR;
        3'b010:  op = all_flag ? OP_PREA : OP_PRE;
        3'b001:  op = OP_REF;
        3'b000:  op = OP_MRS;
        default: op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             close_i,
  input  logic             act_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic             open_q, pend_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      if (close_i) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (ap_i) begin
        pend_q <= 1'b1;
        cnt_q  <= CNT_W'(BURST_LEN);
      end else if (pend_q) begin
        if (cnt_q == CNT_W'(1)) begin
          open_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign open_o = open_q;
  assign pend_o = pend_q;
  assign row_o  = row_q;

  // R5: a pending auto-close only exists on an open bank
  p_pend_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> open_q);

  // R9: clock enable low freezes the slot
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(open_q) && $stable(pend_q) && $stable(row_q)));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       issued_vld,
  output logic [2:0]                 issued_op,
  output logic [BA_W-1:0]            issued_bank,
  output logic                       err_vld,
  output logic [(1<<BA_W)-1:0]       bank_open,
  output logic [(1<<BA_W)-1:0]       ap_pending,
  output logic [(1<<BA_W)*ADDR_W-1:0] row_flat
);
  localparam int NBANK = 1 << BA_W;

  trk_op_e          op;
  logic             legal, bad;
  logic [NBANK-1:0] act_v, close_v, ap_v;
  logic [NBANK-1:0] open_w, pend_w;

  sdram_cmd_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .all_flag (addr[AP_BIT]),
    .op       (op)
  );

  always_comb begin
    legal   = 1'b0;
    bad     = 1'b0;
    act_v   = '0;
    close_v = '0;
    ap_v    = '0;
    if (cke) begin
      case (op)
        OP_ACT: begin
          if (open_w[ba]) bad = 1'b1;
          else begin
            legal     = 1'b1;
            act_v[ba] = 1'b1;
          end
        end
        OP_RD, OP_WR: begin
          if (!open_w[ba] || pend_w[ba]) bad = 1'b1;
          else begin
            legal    = 1'b1;
            ap_v[ba] = addr[AP_BIT];
          end
        end
        OP_PRE: begin
          legal       = 1'b1;
          close_v[ba] = 1'b1;
        end
        OP_PREA: begin
          legal   = 1'b1;
          close_v = '1;
        end
        OP_REF, OP_MRS: begin
          if (|open_w) bad = 1'b1;
          else legal = 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdram_bank_slot #(.ROW_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cke),
      .close_i (close_v[b]),
      .act_i   (act_v[b]),
      .ap_i    (ap_v[b]),
      .row_i   (addr),
      .open_o  (open_w[b]),
      .pend_o  (pend_w[b]),
      .row_o   (row_flat[b*ADDR_W +: ADDR_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issued_vld  <= 1'b0;
      issued_op   <= 3'd0;
      issued_bank <= '0;
      err_vld     <= 1'b0;
    end else begin
      issued_vld  <= legal;
      issued_op   <= op;
      issued_bank <= ba;
      err_vld     <= bad;
    end
  end

  assign bank_open  = open_w;
  assign ap_pending = pend_w;

  // R4: a command is either issued or refused, never both
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(issued_vld && err_vld));

  // R8: a deselected cycle reports nothing
  p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> (!issued_vld && !err_vld));

  // R7: refresh and mode set only go out when every bank was closed
  p_refall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && !cas_n && (|open_w)) |=> !issued_vld);

  // R3: an accepted activate leaves its bank open
  p_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_vld && issued_op == 3'd1) |-> bank_open[issued_bank]);
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
  logic        clk = 1'b0;
  logic        rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        issued_vld, err_vld;
  logic [2:0]  issued_op;
  logic [1:0]  issued_bank;
  logic [3:0]  bank_open, ap_pending;
  logic [51:0] row_flat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .issued_vld(issued_vld), .issued_op(issued_op), .issued_bank(issued_bank),
    .err_vld(err_vld), .bank_open(bank_open), .ap_pending(ap_pending),
    .row_flat(row_flat)
  );

  // [28] cke [27] cs_n [26:24] ras,cas,we [23:22] ba [21:9] addr
  // [8] exp issued [7] exp err [6:4] exp op [3:0] exp open
  localparam int NV = 15;
  localparam logic [28:0] TBL [NV] = '{
    {1'b1,1'b0,3'b111,2'd0,13'h0000,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,1'b0,3'b011,2'd0,13'h0123,1'b1,1'b0,3'd1,4'b0001},
    {1'b1,1'b0,3'b011,2'd2,13'h0ABC,1'b1,1'b0,3'd1,4'b0101},
    {1'b1,1'b0,3'b011,2'd0,13'h0055,1'b0,1'b1,3'd0,4'b0101},
    {1'b1,1'b0,3'b101,2'd1,13'h0000,1'b0,1'b1,3'd0,4'b0101},
    {1'b1,1'b0,3'b101,2'd0,13'h0000,1'b1,1'b0,3'd2,4'b0101},
    {1'b1,1'b0,3'b100,2'd2,13'h0000,1'b1,1'b0,3'd3,4'b0101},
    {1'b1,1'b0,3'b001,2'd0,13'h0000,1'b0,1'b1,3'd0,4'b0101},
    {1'b1,1'b0,3'b010,2'd0,13'h0000,1'b1,1'b0,3'd4,4'b0100},
    {1'b1,1'b0,3'b010,2'd1,13'h0400,1'b1,1'b0,3'd5,4'b0000},
    {1'b1,1'b0,3'b000,2'd0,13'h0033,1'b1,1'b0,3'd7,4'b0000},
    {1'b1,1'b0,3'b001,2'd0,13'h0000,1'b1,1'b0,3'd6,4'b0000},
    {1'b1,1'b1,3'b011,2'd3,13'h0001,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,1'b0,3'b110,2'd0,13'h0000,1'b0,1'b0,3'd0,4'b0000},
    {1'b0,1'b0,3'b011,2'd3,13'h0002,1'b0,1'b0,3'd0,4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; applies the inputs and returns at the next negedge
  task automatic step(input logic k, input logic cs, input logic [2:0] rcw,
                      input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1;
    {ras_n, cas_n, we_n} = 3'b111; ba = 2'd0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 open at reset", {28'd0, bank_open}, 32'd0);
    chk("R1 pending at reset", {28'd0, ap_pending}, 32'd0);
    chk("R1 pulses at reset", {30'd0, issued_vld, err_vld}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][28], TBL[i][27], TBL[i][26:24], TBL[i][23:22], TBL[i][21:9]);
      chk($sformatf("R2/R3/R4/R6/R7/R8/R9 vec%0d issued", i), {31'd0, issued_vld}, {31'd0, TBL[i][8]});
      chk($sformatf("R4/R7 vec%0d err", i), {31'd0, err_vld}, {31'd0, TBL[i][7]});
      if (TBL[i][8]) chk($sformatf("R2 vec%0d op", i), {29'd0, issued_op}, {29'd0, TBL[i][6:4]});
      chk($sformatf("R3/R6 vec%0d open", i), {28'd0, bank_open}, {28'd0, TBL[i][3:0]});
      if (i == 2) begin
        chk("R3 row bank0", {19'd0, row_flat[12:0]}, 32'h0123);
        chk("R3 row bank2", {19'd0, row_flat[38:26]}, 32'h0ABC);
        chk("R2 bank field", {30'd0, issued_bank}, 32'd2);
      end
      if (i == 3) chk("R3 row kept on bad act", {19'd0, row_flat[12:0]}, 32'h0123);
    end

    // R3: activate of the top row in bank 3
    step(1, 0, 3'b011, 2'd3, 13'h1FFF);
    chk("R3 row bank3", {19'd0, row_flat[51:39]}, 32'h1FFF);

    // R5/R8/R9: write with auto-close, countdown through deselect and freeze
    step(1, 0, 3'b011, 2'd1, 13'h0005);
    step(1, 0, 3'b100, 2'd1, 13'h0400);
    chk("R5 write issued", {29'd0, issued_op}, 32'd3);
    chk("R5 pending set", {31'd0, ap_pending[1]}, 32'd1);
    step(1, 0, 3'b101, 2'd1, 13'h0000);
    chk("R4 read on pending bank refused", {31'd0, err_vld}, 32'd1);
    step(1, 1, 3'b011, 2'd1, 13'h0000);
    chk("R8 countdown open", {31'd0, bank_open[1]}, 32'd1);
    step(0, 0, 3'b010, 2'd1, 13'h0400);
    chk("R9 frozen, precharge-all ignored", {28'd0, bank_open}, 32'b1010);
    step(1, 1, 3'b011, 2'd1, 13'h0000);
    chk("R5 still open one edge before", {31'd0, bank_open[1]}, 32'd1);
    step(1, 1, 3'b011, 2'd1, 13'h0000);
    chk("R5/R8 auto-closed", {31'd0, bank_open[1]}, 32'd0);
    chk("R5 pending cleared", {31'd0, ap_pending[1]}, 32'd0);
    chk("R6 other bank untouched", {31'd0, bank_open[3]}, 32'd1);
    step(1, 0, 3'b010, 2'd0, 13'h0400);
    chk("R6 precharge-all", {28'd0, bank_open}, 32'd0);

    // R7: refresh on the expiring edge is refused
    step(1, 0, 3'b011, 2'd0, 13'h0010);
    step(1, 0, 3'b101, 2'd0, 13'h0400);
    step(1, 0, 3'b111, 2'd0, 13'h0000);
    step(1, 0, 3'b111, 2'd0, 13'h0000);
    step(1, 0, 3'b111, 2'd0, 13'h0000);
    chk("R5 open before expiry", {31'd0, bank_open[0]}, 32'd1);
    step(1, 0, 3'b001, 2'd0, 13'h0000);
    chk("R7 refresh at expiry refused", {30'd0, issued_vld, err_vld}, 32'b01);
    chk("R5 closed at expiry", {28'd0, bank_open}, 32'd0);
    step(1, 0, 3'b001, 2'd0, 13'h0000);
    chk("R7 refresh after expiry", {29'd0, issued_op}, 32'd6);
    chk("R7 refresh issued", {30'd0, issued_vld, err_vld}, 32'b10);

    // R6: precharge-all on the expiring edge
    step(1, 0, 3'b011, 2'd0, 13'h0010);
    step(1, 0, 3'b101, 2'd0, 13'h0400);
    step(1, 0, 3'b111, 2'd0, 13'h0000);
    step(1, 0, 3'b111, 2'd0, 13'h0000);
    step(1, 0, 3'b111, 2'd0, 13'h0000);
    step(1, 0, 3'b010, 2'd2, 13'h0400);
    chk("R6 precharge-all at expiry", {30'd0, issued_vld, err_vld}, 32'b10);
    chk("R6 precharge-all op", {29'd0, issued_op}, 32'd5);
    chk("R6 all closed", {28'd0, bank_open, ap_pending}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule